// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two 32-bit translation entries from memory, one after the other. A request carries the linear address plus two flags: one says whether the access is a write, the other whether it comes from user mode. The walker reads a directory entry and then a table entry through a single-outstanding memory read port. It checks the presence, write-permission and user-permission bits of both entries. It then answers with either a physical address or a fault with a cause code.

The walk starts from a root input, which is the base of the active directory, and from a paging-enable input. Both are sampled when a request is accepted. When paging is off, the answer is the linear address itself and memory is not touched. The walker handles one request at a time. Both the request side and the response side use a valid/ready handshake.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A request accepted with `pg_enable` low returns `rsp_paddr` equal to `req_laddr` with `rsp_fault` 0 and `rsp_code` 0, and makes no memory read.
- R3: With paging on, the first memory read goes to `{root_base[31:12], laddr[31:22], 2'b00}`; the low 12 bits of the root are ignored.
- R4: The second memory read goes to `{dir_entry[31:12], laddr[21:12], 2'b00}`.
- R5: A completed walk returns `rsp_paddr = {table_entry[31:12], laddr[11:0]}` with `rsp_fault` 0 and `rsp_code` 0.
- R6: If bit 0 (present) of the directory entry is 0, the walk ends after one read with a fault whose code bit 0 is 0 (not present). Code bit 1 is the write flag and code bit 2 is the user flag of the request.
- R7: If bit 0 of the table entry is 0, the walk ends after two reads with a not-present fault coded as in R6.
- R8: A user access (read or write) faults with code bit 0 set (protection) when bit 2 (user-allowed) is 0 in either entry. Supervisor accesses ignore bit 2.
- R9: A user write faults with code bit 0 set when bit 1 (writable) is 0 in either entry. User reads and all supervisor accesses ignore bit 1.
- R10: A protection or presence failure found in the directory entry ends the walk without reading the table entry.
- R11: `req_ready` is 0 while a walk or a response is pending. `rsp_valid` and its payload hold until `rsp_ready`. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.
- R12: Every fault response carries `rsp_paddr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| root_base | input | 32 | Directory base; bits 31:12 used |
| pg_enable | input | 1 | Paging on; when 0, addresses pass through |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | 1 when the walk failed |
| rsp_code | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |

## Verification
A wrong FSM state or a stale waiting flag shows up at the memory port before it reaches the response. Possible symptoms are a read to the wrong address, an extra or missing table read, or a read that is never issued, which stalls `rsp_valid` forever. A corrupted latched offset or flag shows up only when the response appears, as a wrong address or fault code, two memory round trips after acceptance. The bench therefore checks each read address as it is issued, counts reads per walk, and compares the full response against the expected result.

// File: rtl/pt_walker_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 32-bit entries whose low control bits hold present/writable/user.
package pt_walker_pkg;
    localparam int ENTRY_W   = 32;
    localparam int BIT_P     = 0;
    localparam int BIT_W     = 1;
    localparam int BIT_U     = 2;
    localparam int CODE_W    = 3;
    localparam int CODE_PROT = 0;
    localparam int CODE_WR   = 1;
    localparam int CODE_USER = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_READ_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/pt_entry_check.sv
// Combinational permission check of one translation entry against an access.
// Assumes the caller only uses the result while an entry is being returned.
// Checking each level on its own equals checking the AND of both levels.
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = ENTRY_W
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              ok,
    output logic [CODE_W-1:0] code
);
    logic present;
    logic user_deny;
    logic write_deny;
    logic unused_entry;

    // Decode the entry bits and build the verdict and cause code.
    always_comb begin
        present    = entry[BIT_P];
        user_deny  = acc_user & ~entry[BIT_U];
        write_deny = acc_user & acc_write & ~entry[BIT_W];
        ok         = present & ~user_deny & ~write_deny;
        code            = '0;
        code[CODE_PROT] = present;
        code[CODE_WR]   = acc_write;
        code[CODE_USER] = acc_user;
    end

    assign unused_entry = ^entry[ENT_W-1:BIT_U+1];
endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: accepts one request, issues directory and table reads,
// and holds the result until it is taken.
// Assumes memory returns exactly one response per accepted read, in order.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              pg_enable,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              acc_write,
    output logic              acc_user,
    input  logic              chk_ok,
    input  logic [CODE_W-1:0] chk_code,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code
);
    localparam int ENT_BYTES = ENTRY_W / 8;
    localparam int IDX_LSB   = $clog2(ENT_BYTES);
    localparam int FRAME_W   = ADDR_W - OFF_W;
    localparam int TBL_LSB   = OFF_W;
    localparam int DIR_LSB   = OFF_W + TBL_W;

    walk_state_e       state_q;
    logic              waiting_q;
    logic [TBL_W-1:0]  tbl_q;
    logic [OFF_W-1:0]  off_q;
    logic              wr_q;
    logic              usr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [CODE_W-1:0] code_q;
    logic              unused_low;

    // Sequence the walk: accept, read directory, read table, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            waiting_q <= 1'b0;
            tbl_q     <= '0;
            off_q     <= '0;
            wr_q      <= 1'b0;
            usr_q     <= 1'b0;
            addr_q    <= '0;
            paddr_q   <= '0;
            code_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tbl_q     <= req_laddr[DIR_LSB-1:TBL_LSB];
                        off_q     <= req_laddr[OFF_W-1:0];
                        wr_q      <= req_write;
                        usr_q     <= req_user;
                        code_q    <= '0;
                        waiting_q <= 1'b0;
                        if (pg_enable) begin
                            addr_q  <= {root_base[ADDR_W-1:OFF_W],
                                        req_laddr[ADDR_W-1:DIR_LSB],
                                        {IDX_LSB{1'b0}}};
                            paddr_q <= '0;
                            state_q <= ST_READ_PDE;
                        end else begin
                            paddr_q <= req_laddr;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_READ_PDE: begin
                    if (!waiting_q) begin
                        if (mem_req_ready) waiting_q <= 1'b1;
                    end else if (mem_rsp_valid) begin
                        waiting_q <= 1'b0;
                        if (chk_ok) begin
                            addr_q  <= {mem_rsp_data[ADDR_W-1:OFF_W], tbl_q,
                                        {IDX_LSB{1'b0}}};
                            state_q <= ST_READ_PTE;
                        end else begin
                            code_q  <= chk_code;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (!waiting_q) begin
                        if (mem_req_ready) waiting_q <= 1'b1;
                    end else if (mem_rsp_valid) begin
                        waiting_q <= 1'b0;
                        if (chk_ok) begin
                            paddr_q <= {mem_rsp_data[ADDR_W-1:OFF_W], off_q};
                            state_q <= ST_DONE;
                        end else begin
                            code_q  <= chk_code;
                            state_q <= ST_FAULT;
                        end
                    end
                end
                ST_DONE, ST_FAULT: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake outputs from the state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = ((state_q == ST_READ_PDE) || (state_q == ST_READ_PTE)) && !waiting_q;
        mem_req_addr  = addr_q;
        rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
        rsp_fault     = (state_q == ST_FAULT);
        rsp_paddr     = paddr_q;
        rsp_code      = code_q;
        acc_write     = wr_q;
        acc_user      = usr_q;
    end

    assign unused_low = ^{root_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:0], FRAME_W[0]};

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_code)));
    // R12
    fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pg_enable) |=>
        (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr)));
    // R10
    pde_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_PDE && waiting_q && mem_rsp_valid && !chk_ok) |=>
        (rsp_valid && rsp_fault && !mem_req_valid));
endmodule

// File: rtl/pt_walker.sv
// Top of the two-level page table walker: wires the sequencer to the
// entry permission checker, which judges each returned entry.
// Assumes a 10/10/12 split of a 32-bit address with 4-byte entries by default.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              pg_enable,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code
);
    logic              acc_write;
    logic              acc_user;
    logic              chk_ok;
    logic [CODE_W-1:0] chk_code;

    pt_walk_ctrl #(
        .ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user),
        .root_base(root_base), .pg_enable(pg_enable),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .acc_write(acc_write), .acc_user(acc_user),
        .chk_ok(chk_ok), .chk_code(chk_code),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code)
    );

    pt_entry_check #(.ENT_W(ADDR_W)) u_chk (
        .entry(mem_rsp_data), .acc_write(acc_write), .acc_user(acc_user),
        .ok(chk_ok), .code(chk_code)
    );
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user, pg_enable;
    logic [31:0] req_laddr, root_base;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic        rsp_valid, rsp_ready, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_code;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user),
        .root_base(root_base), .pg_enable(pg_enable),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code)
    );

    // Sparse memory image of translation entries; absent means zero.
    logic [31:0] img_a [16];
    logic [31:0] img_d [16];
    int          img_n = 0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < img_n; i++) if (img_a[i] == a) return img_d[i];
        return 32'h0;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        img_a[img_n] = a;
        img_d[img_n] = d;
        img_n++;
    endtask

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        logic [2:0]  code;
        int          reads;
        logic [31:0] a0;
        logic [31:0] a1;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    int reads_total = 0;
    int reads_base  = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Memory responder: varying ready, two-cycle read latency, address checks.
    initial begin
        int cyc = 0;
        int dly = 0;
        logic [31:0] pend = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend);
                end
            end
            mem_req_ready = (cyc % 3) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pend = mem_req_addr;
                dly  = 2;
                if (exp_q.size() > 0) begin
                    if (reads_total - reads_base == 0)
                        check({"R3 ", tag_q[0]}, "dir read addr", mem_req_addr, exp_q[0].a0);
                    else
                        check({"R4 ", tag_q[0]}, "table read addr", mem_req_addr, exp_q[0].a1);
                end
                reads_total++;
            end
        end
    end

    // Monitor: stalls the response a little, then pops and compares.
    initial begin
        int   hold = 0;
        exp_t e;
        string t;
        rsp_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                check("R11", "req_ready while result pending", {31'b0, req_ready}, 32'h0);
                if (hold < 2) begin
                    rsp_ready = 1'b0;
                    hold++;
                end else begin
                    rsp_ready = 1'b1;
                    hold = 0;
                    if (exp_q.size() == 0) begin
                        check("R11", "unexpected response", 32'h1, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(t, "paddr", rsp_paddr, e.paddr);
                        check(t, "fault", {31'b0, rsp_fault}, {31'b0, e.fault});
                        check(t, "code", {29'b0, rsp_code}, {29'b0, e.code});
                        check(t, "read count", reads_total - reads_base, e.reads);
                    end
                    reads_base = reads_total;
                end
            end else begin
                rsp_ready = 1'b0;
            end
        end
    end

    // Driver: push the expectation, then present the request until taken.
    task automatic send(input string tag, input logic [31:0] la, input logic wr,
                        input logic usr, input logic pg, input logic [31:0] root,
                        input logic [31:0] epa, input logic ef, input logic [2:0] ec,
                        input int nr, input logic [31:0] a0, input logic [31:0] a1);
        exp_t e;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        e.paddr = epa; e.fault = ef; e.code = ec; e.reads = nr; e.a0 = a0; e.a1 = a1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_laddr = la; req_write = wr; req_user = usr; pg_enable = pg; root_base = root;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [31:0] ROOT = 32'h0010_0000;

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_user = 1'b0;
        pg_enable = 1'b0; root_base = '0;
        repeat (3) @(negedge clk);
        check("R1", "req_ready in reset", {31'b0, req_ready}, 32'h1);
        check("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        check("R1", "mem_req_valid in reset", {31'b0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);

        put(32'h0010_0F00, 32'h0020_0007);
        put(32'h0020_0014, 32'h1234_5007);
        put(32'h0020_0018, 32'h1234_6006);
        put(32'h0020_001C, 32'h5555_5003);
        put(32'h0010_0008, 32'h0030_0003);
        put(32'h0030_0008, 32'h0AAA_A001);
        put(32'h0020_0020, 32'h7777_7005);
        put(32'h0010_000C, 32'h0040_0005);
        put(32'h0010_0FFC, 32'h0050_0007);
        put(32'h0050_0FFC, 32'hFFFF_F007);

        send("R2 bypass", 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, ROOT,
             32'hDEAD_BEEF, 1'b0, 3'b000, 0, 32'h0, 32'h0);
        send("R5 user read", 32'hF000_5ABC, 1'b0, 1'b1, 1'b1, ROOT,
             32'h1234_5ABC, 1'b0, 3'b000, 2, 32'h0010_0F00, 32'h0020_0014);
        send("R6 R12 dir absent", 32'h0040_1000, 1'b0, 1'b1, 1'b1, ROOT,
             32'h0, 1'b1, 3'b100, 1, 32'h0010_0004, 32'h0);
        send("R7 R12 table absent", 32'hF000_6010, 1'b1, 1'b0, 1'b1, ROOT,
             32'h0, 1'b1, 3'b010, 2, 32'h0010_0F00, 32'h0020_0018);
        send("R8 user read sup page", 32'hF000_7000, 1'b0, 1'b1, 1'b1, ROOT,
             32'h0, 1'b1, 3'b101, 2, 32'h0010_0F00, 32'h0020_001C);
        send("R8 sup read sup page", 32'hF000_7000, 1'b0, 1'b0, 1'b1, ROOT,
             32'h5555_5000, 1'b0, 3'b000, 2, 32'h0010_0F00, 32'h0020_001C);
        send("R8 R10 user read sup dir", 32'h0080_2004, 1'b0, 1'b1, 1'b1, ROOT,
             32'h0, 1'b1, 3'b101, 1, 32'h0010_0008, 32'h0);
        send("R8 sup read ignores U", 32'h0080_2004, 1'b0, 1'b0, 1'b1, ROOT,
             32'h0AAA_A004, 1'b0, 3'b000, 2, 32'h0010_0008, 32'h0030_0008);
        send("R9 sup write ignores W", 32'h0080_2004, 1'b1, 1'b0, 1'b1, ROOT,
             32'h0AAA_A004, 1'b0, 3'b000, 2, 32'h0010_0008, 32'h0030_0008);
        send("R9 user write ro page", 32'hF000_8123, 1'b1, 1'b1, 1'b1, ROOT,
             32'h0, 1'b1, 3'b111, 2, 32'h0010_0F00, 32'h0020_0020);
        send("R9 user read ro page", 32'hF000_8123, 1'b0, 1'b1, 1'b1, ROOT,
             32'h7777_7123, 1'b0, 3'b000, 2, 32'h0010_0F00, 32'h0020_0020);
        send("R9 R10 user write ro dir", 32'h00C0_0000, 1'b1, 1'b1, 1'b1, ROOT,
             32'h0, 1'b1, 3'b111, 1, 32'h0010_000C, 32'h0);
        send("R3 R5 top corner", 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 32'h0010_0FFF,
             32'hFFFF_FFFF, 1'b0, 3'b000, 2, 32'h0010_0FFC, 32'h0050_0FFC);
        send("R2 bypass zero", 32'h0000_0000, 1'b0, 1'b0, 1'b0, ROOT,
             32'h0000_0000, 1'b0, 3'b000, 0, 32'h0, 32'h0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule